// File: doc/BRIEF.md
# Cycle-Stealing Single-Channel DMA Engine

This block moves a block of bytes between memory and a single peripheral without the processor copying each byte. Software loads a starting memory address and a byte count into registers. It then writes a control word that picks the direction and starts the job. The direction is either memory-to-peripheral or peripheral-to-memory.

For every byte, the engine waits until the peripheral signals that a unit is ready. It then asks the bus arbiter for the address and data buses. Once the grant arrives, it moves exactly one byte and hands the buses straight back. The processor therefore loses the bus for one short window per byte, and never for a whole burst.

The address advances by one and the remaining count drops by one after each byte. When the count runs out, the engine raises an interrupt. The interrupt stays up until software acknowledges it by writing a one to the done bit. Memory is modelled as a combinational read port and a write strobe, and the arbiter as a request/grant pair.

Top module: `dma_cycle_steal`

## Requirements
- R1: After reset, busReq, irq, memRdEn, memWrEn, perWrStrobe and perRdStrobe are low, and every register reads back as zero.
- R2: The register map is as follows. regSel 0 is the start address. regSel 1 is the remaining byte count. regSel 2 is control: bit 0 starts the job, bit 1 is the direction (0 = memory to peripheral, 1 = peripheral to memory). regSel 3 is status: bit 0 is busy, bit 1 is done. Written values read back on regRdData in the same cycle the select is applied.
- R3: While a job is active, busReq stays low for as long as perReady is low.
- R4: busReq rises the cycle after perReady is seen and stays high until busGrant is sampled high. The byte moves in the following cycle. busReq is low in the cycle after the move.
- R5: In a memory-to-peripheral move, memRdEn and perWrStrobe are high for one cycle, perWrData equals memRdData, memAddr is the current address, and memWrEn stays low.
- R6: In a peripheral-to-memory move, memWrEn and perRdStrobe are high for one cycle, memWrData equals perRdData, memAddr is the current address, and memRdEn stays low.
- R7: After each byte, the address register increases by 1 and the count register decreases by 1.
- R8: When the last byte has moved, status reads done=1 and busy=0, irq is high, and busReq stays low.
- R9: Writing status with bit 1 set clears done and irq. Writing status with bit 1 clear leaves both unchanged.
- R10: Register writes made while busy are ignored, including a write that lands in the same cycle as a byte move. In that case the address still steps and the done flag is still set.
- R11: Starting with a count of zero sets done and irq the next cycle, with no bus request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe from the processor |
| regSel | input | 2 | Register select |
| regWrData | input | REG_W | Register write data |
| regRdData | output | REG_W | Register read data for regSel |
| perReady | input | 1 | Peripheral has a unit ready / can take one |
| perRdData | input | UNIT_W | Byte offered by the peripheral |
| perRdStrobe | output | 1 | Peripheral byte consumed |
| perWrData | output | UNIT_W | Byte delivered to the peripheral |
| perWrStrobe | output | 1 | Peripheral byte delivered |
| busReq | output | 1 | Bus request to the arbiter |
| busGrant | input | 1 | Bus grant from the arbiter |
| memAddr | output | ADDR_W | Memory address of the current byte |
| memRdEn | output | 1 | Memory read strobe |
| memRdData | input | UNIT_W | Memory read data (combinational) |
| memWrEn | output | 1 | Memory write strobe |
| memWrData | output | UNIT_W | Memory write data |
| irq | output | 1 | Completion interrupt |

## Verification
Two events can fall in the same cycle: a processor register write and the final byte move, which also sets done. The bench provokes this by driving a status-clear write during the move cycle of the last byte. It then checks three things: done and irq both end high, the write left no trace, and the address still stepped past the last byte. Separate runs vary the grant latency and the direction. Those runs check that the request never appears without perReady and drops right after each move.

// File: rtl/dma_steal_pkg.sv
package dma_steal_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_REQ,
    ST_XFER
  } dmaState_t;

  typedef struct packed {
    logic loadAddr;
    logic loadCount;
    logic loadDir;
    logic step;
  } dmaStrobe_t;

  localparam logic [1:0] SEL_ADDR   = 2'd0;
  localparam logic [1:0] SEL_COUNT  = 2'd1;
  localparam logic [1:0] SEL_CTRL   = 2'd2;
  localparam logic [1:0] SEL_STATUS = 2'd3;

  localparam int CTRL_START = 0;
  localparam int CTRL_DIR   = 1;
  localparam int STAT_BUSY  = 0;
  localparam int STAT_DONE  = 1;

endpackage

// File: rtl/dma_steal_ctrl.sv
module dma_steal_ctrl
  import dma_steal_pkg::*;
#(
  parameter int REG_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [1:0]       regSel,
  input  logic [REG_W-1:0] regWrData,
  input  logic             countZero,
  input  logic             countOne,
  input  logic             perReady,
  input  logic             busGrant,
  output dmaStrobe_t       strobe,
  output logic             busy,
  output logic             done,
  output logic             busReq,
  output logic             xferNow
);

  dmaState_t state, stateNext;
  logic idleWr;
  logic startReq;
  logic clearReq;

  assign busy     = (state != ST_IDLE);
  assign idleWr   = regWrEn && !busy;
  assign startReq = idleWr && (regSel == SEL_CTRL) && regWrData[CTRL_START];
  assign clearReq = idleWr && (regSel == SEL_STATUS) && regWrData[STAT_DONE];

  assign strobe.loadAddr  = idleWr && (regSel == SEL_ADDR);
  assign strobe.loadCount = idleWr && (regSel == SEL_COUNT);
  assign strobe.loadDir   = idleWr && (regSel == SEL_CTRL);
  assign strobe.step      = (state == ST_XFER);

  assign busReq  = (state == ST_REQ) || (state == ST_XFER);
  assign xferNow = (state == ST_XFER);

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (startReq && !countZero) stateNext = ST_WAIT;
      ST_WAIT: if (perReady) stateNext = ST_REQ;
      ST_REQ:  if (busGrant) stateNext = ST_XFER;
      ST_XFER: stateNext = countOne ? ST_IDLE : ST_WAIT;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= stateNext;
      if (startReq) begin
        done <= countZero;
      end else if ((state == ST_XFER) && countOne) begin
        done <= 1'b1;
      end else if (clearReq) begin
        done <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/dma_steal_dp.sv
module dma_steal_dp
  import dma_steal_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int COUNT_W = 16,
  parameter int UNIT_W  = 8,
  parameter int REG_W   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dmaStrobe_t        strobe,
  input  logic [1:0]        regSel,
  input  logic [REG_W-1:0]  regWrData,
  input  logic              busy,
  input  logic              done,
  input  logic [UNIT_W-1:0] memRdData,
  input  logic [UNIT_W-1:0] perRdData,
  output logic              countZero,
  output logic              countOne,
  output logic [REG_W-1:0]  regRdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRdEn,
  output logic              memWrEn,
  output logic [UNIT_W-1:0] memWrData,
  output logic [UNIT_W-1:0] perWrData,
  output logic              perWrStrobe,
  output logic              perRdStrobe
);

  localparam logic [ADDR_W-1:0]  ADDR_ONE  = ADDR_W'(1);
  localparam logic [COUNT_W-1:0] COUNT_ONE = COUNT_W'(1);

  logic [ADDR_W-1:0]  addrQ;
  logic [COUNT_W-1:0] countQ;
  logic               dirQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      countQ <= '0;
      dirQ   <= 1'b0;
    end else begin
      if (strobe.loadAddr) begin
        addrQ <= regWrData[ADDR_W-1:0];
      end else if (strobe.step) begin
        addrQ <= addrQ + ADDR_ONE;
      end
      if (strobe.loadCount) begin
        countQ <= regWrData[COUNT_W-1:0];
      end else if (strobe.step) begin
        countQ <= countQ - COUNT_ONE;
      end
      if (strobe.loadDir) begin
        dirQ <= regWrData[CTRL_DIR];
      end
    end
  end

  assign countZero = (countQ == '0);
  assign countOne  = (countQ == COUNT_ONE);

  assign memAddr     = addrQ;
  assign memRdEn     = strobe.step && !dirQ;
  assign perWrStrobe = strobe.step && !dirQ;
  assign memWrEn     = strobe.step && dirQ;
  assign perRdStrobe = strobe.step && dirQ;
  assign perWrData   = memRdData;
  assign memWrData   = perRdData;

  always_comb begin
    regRdData = '0;
    unique case (regSel)
      SEL_ADDR:  regRdData = REG_W'(addrQ);
      SEL_COUNT: regRdData = REG_W'(countQ);
      SEL_CTRL:  regRdData[CTRL_DIR] = dirQ;
      default: begin
        regRdData[STAT_BUSY] = busy;
        regRdData[STAT_DONE] = done;
      end
    endcase
  end

endmodule

// File: rtl/dma_cycle_steal.sv
module dma_cycle_steal
  import dma_steal_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int COUNT_W = 16,
  parameter int UNIT_W  = 8,
  parameter int REG_W   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [1:0]        regSel,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  input  logic              perReady,
  input  logic [UNIT_W-1:0] perRdData,
  output logic              perRdStrobe,
  output logic [UNIT_W-1:0] perWrData,
  output logic              perWrStrobe,
  output logic              busReq,
  input  logic              busGrant,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRdEn,
  input  logic [UNIT_W-1:0] memRdData,
  output logic              memWrEn,
  output logic [UNIT_W-1:0] memWrData,
  output logic              irq
);

  dmaStrobe_t strobe;
  logic busy;
  logic done;
  logic countZero;
  logic countOne;
  logic xferNow;

  dma_steal_ctrl #(.REG_W(REG_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regSel(regSel), .regWrData(regWrData),
    .countZero(countZero), .countOne(countOne),
    .perReady(perReady), .busGrant(busGrant),
    .strobe(strobe), .busy(busy), .done(done),
    .busReq(busReq), .xferNow(xferNow)
  );

  dma_steal_dp #(
    .ADDR_W(ADDR_W), .COUNT_W(COUNT_W), .UNIT_W(UNIT_W), .REG_W(REG_W)
  ) u_dp (
    .clk(clk), .rstN(rstN),
    .strobe(strobe), .regSel(regSel), .regWrData(regWrData),
    .busy(busy), .done(done),
    .memRdData(memRdData), .perRdData(perRdData),
    .countZero(countZero), .countOne(countOne),
    .regRdData(regRdData), .memAddr(memAddr),
    .memRdEn(memRdEn), .memWrEn(memWrEn), .memWrData(memWrData),
    .perWrData(perWrData), .perWrStrobe(perWrStrobe), .perRdStrobe(perRdStrobe)
  );

  assign irq = done;

endmodule

// File: rtl/dma_cycle_steal_chk.sv
module dma_cycle_steal_chk #(
  parameter int ADDR_W = 16,
  parameter int UNIT_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic              busReq,
  input logic              busGrant,
  input logic              memRdEn,
  input logic              memWrEn,
  input logic              perWrStrobe,
  input logic              perRdStrobe,
  input logic [ADDR_W-1:0] memAddr,
  input logic [UNIT_W-1:0] memWrData,
  input logic [UNIT_W-1:0] perRdData,
  input logic              irq
);

  logic moving;
  assign moving = memRdEn || memWrEn;

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    busReq && !busGrant && !moving |=> busReq); // R4
  AST_MOVE_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    busReq && busGrant && !moving |=> moving); // R4
  AST_REQ_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    moving |=> !busReq); // R4
  AST_MOVE_UNDER_REQ: assert property (@(posedge clk) disable iff (!rstN)
    moving |-> busReq); // R4
  AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({memRdEn, memWrEn})); // R5
  AST_READ_PAIRS: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |-> perWrStrobe && !perRdStrobe); // R5
  AST_WRITE_PAIRS: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> perRdStrobe && !perWrStrobe && (memWrData == perRdData)); // R6
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    moving |=> memAddr == ADDR_W'($past(memAddr) + 1'b1)); // R7
  AST_NO_IRQ_WHILE_REQ: assert property (@(posedge clk) disable iff (!rstN)
    busReq |-> !irq); // R8
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    irq && !regWrEn |=> irq); // R9

endmodule

bind dma_cycle_steal dma_cycle_steal_chk #(.ADDR_W(ADDR_W), .UNIT_W(UNIT_W)) u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn),
  .busReq(busReq), .busGrant(busGrant),
  .memRdEn(memRdEn), .memWrEn(memWrEn),
  .perWrStrobe(perWrStrobe), .perRdStrobe(perRdStrobe),
  .memAddr(memAddr), .memWrData(memWrData), .perRdData(perRdData),
  .irq(irq)
);

// File: tb/test_dma_cycle_steal.sv
module test_dma_cycle_steal;

  localparam int ADDR_W = 16;
  localparam int UNIT_W = 8;
  localparam int REG_W  = 16;

  // dir[47:44] start[43:28] count[27:20] grantLatency[19:16] endAddr[15:0]
  localparam logic [47:0] VECS [4] = '{
    {4'd0, 16'h0010, 8'd3, 4'd0, 16'h0013},
    {4'd1, 16'h0040, 8'd2, 4'd2, 16'h0042},
    {4'd0, 16'h00FE, 8'd3, 4'd1, 16'h0101},
    {4'd1, 16'h0080, 8'd1, 4'd3, 16'h0081}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [1:0] regSel = 2'd0;
  logic [REG_W-1:0] regWrData = '0;
  logic [REG_W-1:0] regRdData;
  logic perReady = 1'b0;
  logic [UNIT_W-1:0] perRdData = '0;
  logic perRdStrobe;
  logic [UNIT_W-1:0] perWrData;
  logic perWrStrobe;
  logic busReq;
  logic busGrant = 1'b0;
  logic [ADDR_W-1:0] memAddr;
  logic memRdEn;
  logic [UNIT_W-1:0] memRdData;
  logic memWrEn;
  logic [UNIT_W-1:0] memWrData;
  logic irq;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  function automatic logic [UNIT_W-1:0] memPattern(input logic [ADDR_W-1:0] a);
    return UNIT_W'(a[7:0] * 8'd7 + 8'd3);
  endfunction

  assign memRdData = memPattern(memAddr);

  dma_cycle_steal i_dma_cycle_steal (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regSel(regSel), .regWrData(regWrData), .regRdData(regRdData),
    .perReady(perReady), .perRdData(perRdData), .perRdStrobe(perRdStrobe),
    .perWrData(perWrData), .perWrStrobe(perWrStrobe),
    .busReq(busReq), .busGrant(busGrant),
    .memAddr(memAddr), .memRdEn(memRdEn), .memRdData(memRdData),
    .memWrEn(memWrEn), .memWrData(memWrData), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] sel, input logic [REG_W-1:0] data);
    regWrEn = 1'b1; regSel = sel; regWrData = data;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic readReg(input logic [1:0] sel, output logic [REG_W-1:0] val);
    regSel = sel;
    #1;
    val = regRdData;
  endtask

  // One byte move; entered at a negedge with the engine waiting on the peripheral.
  task automatic doUnit(input logic dir, input logic [ADDR_W-1:0] addrExp,
                        input int remainAfter, input int lat, input int u, input bit collide);
    logic [REG_W-1:0] rd;
    perReady = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R3 no request without perReady", busReq, 0);
    perReady = 1'b1;
    perRdData = UNIT_W'(8'hA0 ^ u[7:0]);
    @(negedge clk);
    perReady = 1'b0;
    chk("R4 request raised", busReq, 1);
    for (int k = 0; k < lat; k++) begin
      @(negedge clk);
      chk("R4 request held without grant", busReq, 1);
    end
    busGrant = 1'b1;
    @(negedge clk);
    busGrant = 1'b0;
    chk("R5/R6 memAddr at move", memAddr, addrExp);
    if (!dir) begin
      chk("R5 memRdEn", memRdEn, 1);
      chk("R5 perWrStrobe", perWrStrobe, 1);
      chk("R5 perWrData", perWrData, memPattern(addrExp));
      chk("R5 memWrEn low", memWrEn, 0);
    end else begin
      chk("R6 memWrEn", memWrEn, 1);
      chk("R6 perRdStrobe", perRdStrobe, 1);
      chk("R6 memWrData", memWrData, 8'hA0 ^ u[7:0]);
      chk("R6 memRdEn low", memRdEn, 0);
    end
    if (collide) begin
      regWrEn = 1'b1; regSel = 2'd3; regWrData = 16'h0002;
    end
    @(negedge clk);
    regWrEn = 1'b0;
    chk("R4 request dropped after move", busReq, 0);
    readReg(2'd1, rd);
    chk("R7 count decrements", rd, remainAfter);
    readReg(2'd0, rd);
    chk("R7 address increments", rd, addrExp + 1'b1);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [REG_W-1:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 busReq", busReq, 0);
    chk("R1 irq", irq, 0);
    chk("R1 strobes", {memRdEn, memWrEn, perWrStrobe, perRdStrobe}, 0);
    for (int s = 0; s < 4; s++) begin
      readReg(2'(s), rd);
      chk("R1 register zero", rd, 0);
    end

    // R2 programming and readback
    regWrite(2'd0, 16'h1234);
    readReg(2'd0, rd); chk("R2 address readback", rd, 16'h1234);
    regWrite(2'd1, 16'd5);
    readReg(2'd1, rd); chk("R2 count readback", rd, 5);
    regWrite(2'd2, 16'h0002);
    readReg(2'd2, rd); chk("R2 direction readback", rd, 16'h0002);
    readReg(2'd3, rd); chk("R2 idle status", rd, 0);

    // Table of jobs
    for (int v = 0; v < 4; v++) begin
      logic dir;
      logic [15:0] start;
      int cnt, lat;
      logic [15:0] endA;
      dir   = VECS[v][44];
      start = VECS[v][43:28];
      cnt   = int'(VECS[v][27:20]);
      lat   = int'(VECS[v][19:16]);
      endA  = VECS[v][15:0];
      regWrite(2'd0, start);
      regWrite(2'd1, 16'(cnt));
      regWrite(2'd2, {14'd0, dir, 1'b1});
      readReg(2'd3, rd); chk("R2 busy while active", rd, 16'h0001);
      for (int u = 0; u < cnt; u++) begin
        doUnit(dir, start + 16'(u), cnt - u - 1, lat, u, 1'b0);
      end
      readReg(2'd3, rd); chk("R8 done and idle", rd, 16'h0002);
      chk("R8 irq raised", irq, 1);
      readReg(2'd0, rd); chk("R7 final address", rd, endA);
      @(negedge clk);
      chk("R8 no request after completion", busReq, 0);
      regWrite(2'd3, 16'h0002);
      chk("R9 irq cleared", irq, 0);
      readReg(2'd3, rd); chk("R9 done cleared", rd, 0);
    end

    // R10 writes while busy, plus a clear colliding with the final move
    regWrite(2'd0, 16'h0020);
    regWrite(2'd1, 16'd2);
    regWrite(2'd2, 16'h0001);
    regWrite(2'd0, 16'h5555);
    readReg(2'd0, rd); chk("R10 address write ignored", rd, 16'h0020);
    regWrite(2'd1, 16'd9);
    readReg(2'd1, rd); chk("R10 count write ignored", rd, 2);
    regWrite(2'd2, 16'h0003);
    readReg(2'd2, rd); chk("R10 control write ignored", rd, 0);
    doUnit(1'b0, 16'h0020, 1, 1, 0, 1'b0);
    doUnit(1'b0, 16'h0021, 0, 0, 1, 1'b1);
    chk("R10 done survives colliding clear", irq, 1);
    readReg(2'd3, rd); chk("R10 status after collision", rd, 16'h0002);
    regWrite(2'd3, 16'h0002);

    // R11 zero count
    regWrite(2'd1, 16'd0);
    regWrite(2'd2, 16'h0001);
    readReg(2'd3, rd); chk("R11 done immediately", rd, 16'h0002);
    chk("R11 irq immediately", irq, 1);
    perReady = 1'b1;
    @(negedge clk); @(negedge clk);
    perReady = 1'b0;
    chk("R11 no bus request", busReq, 0);

    // R9 write of zero keeps done
    regWrite(2'd3, 16'h0000);
    chk("R9 zero write keeps irq", irq, 1);
    regWrite(2'd3, 16'h0002);
    chk("R9 clear", irq, 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule